// File: doc/BRIEF.md
# SPI Master Controller with Register Port

This block is a full-duplex SPI master for 8-bit words. Software drives it through a single-cycle register port with 32-bit data. Bytes written to a transmit port enter a byte FIFO. The shift engine sends each byte MSB first on MOSI and captures one byte from MISO for every byte it sends. The captured bytes go into a receive FIFO, which software pops through a read port. The serial clock runs at a fixed rate: its half-period is a build-time number of system clocks and cannot be changed from software. All four clock polarity and phase combinations are available. Up to 32 active-low select lines are driven (16 by default).

The usual sequence is as follows. With the transmit-inhibit bit set, software loads a burst into the transmit FIFO. It then clears inhibit, and the engine sends the queued bytes back to back. When the last byte has finished and the transmit FIFO is empty, the TX-empty interrupt bit is set. Select lines either follow the select register directly (manual mode) or are driven only while a byte is on the wire (automatic mode). Six interrupt status bits are cleared by writing one. A per-bit enable mask and a global gate decide whether they raise the interrupt output. Writing a fixed key to the reset register returns every register and both FIFOs to their defaults.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, control (offset 0x60) reads 0x100 (inhibit set, all else clear). Status (0x64) reads 0x05. Select (0x70) reads all ones. Interrupt status (0x20) reads 0. `irq` is 0, `spi_sck` is 0 and every `spi_ss_n` line is high.
- R2: A byte starts shifting only when control bit1 (enable) and bit2 (master) are set and bit8 (inhibit) is clear. Otherwise queued bytes stay in the transmit FIFO, SCK does not toggle, and status bit2 (TX empty) stays 0.
- R3: A write to 0x68 queues its low byte. Each byte goes out MSB first on MOSI while one byte is captured MSB first from MISO. A read of 0x6C pops the captured bytes in arrival order in bits 7:0.
- R4: SCK idles at control bit3 (CPOL). When control bit4 (CPHA) is 0, MOSI is valid before the first SCK edge and MISO is sampled on the leading edge. When CPHA is 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Each SCK half-period lasts exactly CLK_DIV system clocks.
- R6: Queued bytes run back to back, with one idle system clock between consecutive bytes. For three bytes, the first leading edge and the last trailing edge are 47*CLK_DIV+2 clocks apart.
- R7: The transmit FIFO holds FIFO_DEPTH bytes. Status bit3 (TX full) is set when it is full, and a write to a full FIFO is dropped.
- R8: Status bit0 is RX empty and bit1 is RX full. Interrupt status bit4 is set when the receive FIFO becomes full. A byte that completes while the receive FIFO is full is dropped and sets interrupt status bit5 (overrun).
- R9: Interrupt status bit2 is set when a byte finishes and the transmit FIFO is empty. Writing a 1 to an interrupt status bit clears that bit.
- R10: `irq` is high exactly when bit31 of 0x1C (global enable) is set and some interrupt status bit is also set in the enable mask at 0x28.
- R11: With control bit7 (manual select) set, `spi_ss_n` equals the select register at all times. With it clear, `spi_ss_n` equals the select register while a byte shifts and is all ones otherwise.
- R12: Writing 0x0A to 0x40 restores every register and empties both FIFOs. Writing any other value to 0x40 has no effect.
- R13: Writing control with bit5 set empties the transmit FIFO, and writing it with bit6 set empties the receive FIFO. Both bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSS | Active-low select lines |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs each clock mode against a slave model that samples on the edge the mode prescribes. A design that samples on the wrong edge returns a byte shifted by one bit, or echoes its own data. Timestamps of the SCK edges catch a half-period that is off by a clock, and a burst that waits too long between bytes. The FIFO limits are driven past their ends. A design that keeps the seventeenth transmit byte sends one byte too many, and one that overwrites on overrun changes the count or content of the received bytes. The reset key is tested with a wrong value before the right one, and the select lines are observed both idle and mid-byte, so a block that resets on any write, or that leaves the automatic select asserted while idle, is exposed.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int BYTE_W = 8;
   localparam int IRQ_N  = 6;

   // register offsets
   localparam logic [7:0] OFS_GIE  = 8'h1C;
   localparam logic [7:0] OFS_ISR  = 8'h20;
   localparam logic [7:0] OFS_IER  = 8'h28;
   localparam logic [7:0] OFS_SRST = 8'h40;
   localparam logic [7:0] OFS_CTRL = 8'h60;
   localparam logic [7:0] OFS_STAT = 8'h64;
   localparam logic [7:0] OFS_TXD  = 8'h68;
   localparam logic [7:0] OFS_RXD  = 8'h6C;
   localparam logic [7:0] OFS_SSEL = 8'h70;

   localparam logic [31:0] SRST_KEY = 32'h0000_000A;

   // control bit positions in the 32-bit word
   localparam int CB_TXFLUSH = 5;
   localparam int CB_RXFLUSH = 6;

   // interrupt status positions
   localparam int IB_TXEMPTY = 2;
   localparam int IB_RXFULL  = 4;
   localparam int IB_RXOVR   = 5;

   // control word bits 8..1 (bit 0 of the word is unused)
   typedef struct packed {
      logic inhibit;
      logic manual;
      logic rx_flush;
      logic tx_flush;
      logic cpha;
      logic cpol;
      logic master;
      logic enable;
   } ctrl_t;

   localparam ctrl_t CTRL_RST    = ctrl_t'(8'h80);
   localparam logic [7:0] CTRL_KEEP = 8'b1100_1111;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
   parameter int CLK_DIV = 2,
   parameter int BW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          cpol,
   input  logic          cpha,
   input  logic          start,
   input  logic [BW-1:0] tx_byte,
   input  logic          miso,
   output logic          busy,
   output logic          done,
   output logic [BW-1:0] rx_byte,
   output logic          sck,
   output logic          mosi
);
   localparam int BCW = $clog2(BW);
   localparam int DCW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("spim_engine: CLK_DIV must be at least 1");
   end

   logic           tick;
   logic           phase;
   logic [BCW-1:0] bit_idx;
   logic [BW-1:0]  tx_sh, rx_sh;
   logic           mosi_q;

   if (CLK_DIV == 1) begin : g_nodiv
      assign tick = busy;
   end else begin : g_div
      logic [DCW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   dcnt <= '0;
         else if (clr || !busy || tick) dcnt <= '0;
         else                           dcnt <= dcnt + 1'b1;
      end
      assign tick = busy && (dcnt == DCW'(CLK_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; phase <= 1'b0; bit_idx <= '0;
         tx_sh <= '0; rx_sh <= '0; mosi_q <= 1'b0;
      end else if (clr) begin
         busy <= 1'b0; done <= 1'b0; phase <= 1'b0; bit_idx <= '0;
         tx_sh <= '0; rx_sh <= '0; mosi_q <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               phase   <= 1'b0;
               bit_idx <= '0;
               if (cpha) begin
                  tx_sh <= tx_byte;
               end else begin
                  tx_sh  <= {tx_byte[BW-2:0], 1'b0};
                  mosi_q <= tx_byte[BW-1];
               end
            end
         end else if (tick) begin
            phase <= ~phase;
            if (!phase) begin
               // leading edge
               if (cpha) begin
                  mosi_q <= tx_sh[BW-1];
                  tx_sh  <= {tx_sh[BW-2:0], 1'b0};
               end else begin
                  rx_sh <= {rx_sh[BW-2:0], miso};
               end
            end else begin
               // trailing edge
               if (cpha) begin
                  rx_sh <= {rx_sh[BW-2:0], miso};
               end else if (bit_idx != BCW'(BW - 1)) begin
                  mosi_q <= tx_sh[BW-1];
                  tx_sh  <= {tx_sh[BW-2:0], 1'b0};
               end
               bit_idx <= bit_idx + 1'b1;
               if (bit_idx == BCW'(BW - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   assign rx_byte = rx_sh;
   assign sck     = cpol ^ phase;
   assign mosi    = mosi_q;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int NSS        = 16,
   parameter int FIFO_DEPTH = 16,
   parameter int CLK_DIV    = 2,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NSS-1:0]    spi_ss_n,
   output logic              irq
);
   if (NSS < 1 || NSS > 32) begin : g_bad_nss
      $error("spim_ctrl: NSS must lie in 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("spim_ctrl: ADDR_W must be at least 8");
   end

   logic              wr, rd, srst;
   logic [7:0]        ofs;
   ctrl_t             ctrl;
   logic [NSS-1:0]    ssr;
   logic [IRQ_N-1:0]  isr, ier, isr_set;
   logic              gie, rx_full_d;
   logic              tx_push, tx_flush, rx_pop, rx_flush;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [BYTE_W-1:0] tx_head, rx_head, eng_rx;
   logic              eng_start, eng_busy, eng_done;

   assign ofs  = bus_addr[7:0];
   assign wr   = bus_sel & bus_wr & (bus_addr[ADDR_W-1:8] == '0);
   assign rd   = bus_sel & ~bus_wr & (bus_addr[ADDR_W-1:8] == '0);
   assign srst = wr && (ofs == OFS_SRST) && (bus_wdata == SRST_KEY);

   assign tx_push  = wr && (ofs == OFS_TXD);
   assign rx_pop   = rd && (ofs == OFS_RXD);
   assign tx_flush = srst || (wr && (ofs == OFS_CTRL) && bus_wdata[CB_TXFLUSH]);
   assign rx_flush = srst || (wr && (ofs == OFS_CTRL) && bus_wdata[CB_RXFLUSH]);

   assign eng_start = ctrl.enable & ctrl.master & ~ctrl.inhibit & ~tx_empty & ~eng_busy;

   spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_flush), .push(tx_push),
      .din(bus_wdata[BYTE_W-1:0]), .pop(eng_start), .dout(tx_head),
      .empty(tx_empty), .full(tx_full));

   spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_flush), .push(eng_done),
      .din(eng_rx), .pop(rx_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full));

   spim_engine #(.CLK_DIV(CLK_DIV), .BW(BYTE_W)) i_eng (
      .clk(clk), .rst_n(rst_n), .clr(srst), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
      .start(eng_start), .tx_byte(tx_head), .miso(spi_miso), .busy(eng_busy),
      .done(eng_done), .rx_byte(eng_rx), .sck(spi_sck), .mosi(spi_mosi));

   always_comb begin
      isr_set             = '0;
      isr_set[IB_TXEMPTY] = eng_done & tx_empty;
      isr_set[IB_RXFULL]  = rx_full & ~rx_full_d;
      isr_set[IB_RXOVR]   = eng_done & rx_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= CTRL_RST; ssr <= '1; isr <= '0; ier <= '0; gie <= 1'b0; rx_full_d <= 1'b0;
      end else if (srst) begin
         ctrl <= CTRL_RST; ssr <= '1; isr <= '0; ier <= '0; gie <= 1'b0; rx_full_d <= 1'b0;
      end else begin
         rx_full_d <= rx_full;
         if (wr && ofs == OFS_CTRL) ctrl <= ctrl_t'(bus_wdata[8:1] & CTRL_KEEP);
         if (wr && ofs == OFS_SSEL) ssr  <= bus_wdata[NSS-1:0];
         if (wr && ofs == OFS_IER)  ier  <= bus_wdata[IRQ_N-1:0];
         if (wr && ofs == OFS_GIE)  gie  <= bus_wdata[31];
         if (wr && ofs == OFS_ISR)  isr  <= (isr & ~bus_wdata[IRQ_N-1:0]) | isr_set;
         else                       isr  <= isr | isr_set;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (ofs)
            OFS_GIE:  bus_rdata[31] = gie;
            OFS_ISR:  bus_rdata[IRQ_N-1:0] = isr;
            OFS_IER:  bus_rdata[IRQ_N-1:0] = ier;
            OFS_CTRL: bus_rdata[8:1] = ctrl;
            OFS_STAT: bus_rdata[4:0] = {1'b0, tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:  bus_rdata[BYTE_W-1:0] = rx_head;
            OFS_SSEL: bus_rdata[NSS-1:0] = ssr;
            default:  bus_rdata = '0;
         endcase
      end
   end

   for (genvar i = 0; i < NSS; i++) begin : g_ss
      assign spi_ss_n[i] = (ctrl.manual || eng_busy) ? ssr[i] : 1'b1;
   end

   assign irq = gie & (|(isr & ier));
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
   parameter int NSS = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           srst,
   input logic [7:0]     ctrl_word,
   input logic           busy,
   input logic           done,
   input logic           start,
   input logic           tx_empty,
   input logic           tx_full,
   input logic           tx_flush,
   input logic           isr_txe,
   input logic           sck,
   input logic [NSS-1:0] ss_n,
   input logic           gie,
   input logic           irq
);
   // ctrl_word bit7 inhibit, bit6 manual, bit2 cpol
   AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[7] && !busy) |=> !busy); // R2
   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == ctrl_word[2])); // R4
   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !start && !tx_flush) |=> tx_full); // R7
   AST_TXE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tx_empty && !srst) |=> isr_txe); // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq); // R10
   AST_AUTO_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_word[6] && !busy) |-> (ss_n == '1)); // R11
   AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctrl_word == 8'h80 && !busy && tx_empty)); // R12
endmodule

bind spim_ctrl spim_ctrl_chk #(.NSS(NSS)) i_chk (
   .clk(clk), .rst_n(rst_n), .srst(srst), .ctrl_word(ctrl), .busy(eng_busy),
   .done(eng_done), .start(eng_start), .tx_empty(tx_empty), .tx_full(tx_full),
   .tx_flush(tx_flush), .isr_txe(isr[2]), .sck(spi_sck), .ss_n(spi_ss_n),
   .gie(gie), .irq(irq));

// File: tb/test_spim_ctrl.sv
module test_spim_ctrl;
   localparam int TCLK = 10;
   localparam int DIV  = 2;
   localparam int NSS  = 16;

   localparam logic [7:0] A_GIE = 8'h1C, A_ISR = 8'h20, A_IER = 8'h28, A_SRST = 8'h40;
   localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68, A_RXD = 8'h6C, A_SSEL = 8'h70;

   // {cpol, cpha, master byte, slave byte}
   localparam logic [17:0] VEC [8] = '{
      {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h81, 8'h7E}, {2'b10, 8'h5A, 8'hC3}, {2'b11, 8'h01, 8'h80},
      {2'b00, 8'hFF, 8'h00}, {2'b01, 8'h96, 8'h69}, {2'b10, 8'h0F, 8'hF0}, {2'b11, 8'hE7, 8'h18}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic spi_sck, spi_mosi, spi_miso, irq;
   logic [NSS-1:0] spi_ss_n;

   int n_chk = 0, n_err = 0;
   logic [31:0] cr_cur;

   // slave model state
   logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
   int slv_pos = 0, slv_bits = 0, edges = 0;
   logic cur_cpol = 1'b0, cur_cpha = 1'b0;
   time last_t = 0, t_first = 0, hp_min = 1000000;
   bit have_t = 0;

   always #(TCLK/2) clk = ~clk;

   spim_ctrl #(.NSS(NSS), .FIFO_DEPTH(16), .CLK_DIV(DIV), .ADDR_W(8)) i_spim_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_ss_n(spi_ss_n), .irq(irq));

   assign spi_miso = slv_tx[3'(7 - slv_pos)];

   always @(spi_sck) begin
      if (have_t && ($time - last_t) < hp_min) hp_min = $time - last_t;
      last_t = $time;
      have_t = 1;
      edges++;
      if (edges == 1) t_first = $time;
      if (spi_sck !== cur_cpol) begin
         if (!cur_cpha) begin #1; slv_rx = {slv_rx[6:0], spi_mosi}; slv_bits++; end
         else slv_pos = (slv_pos + 1) % 8;
      end else begin
         if (!cur_cpha) slv_pos = (slv_pos + 1) % 8;
         else begin #1; slv_rx = {slv_rx[6:0], spi_mosi}; slv_bits++; end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // configure mode with inhibit set, then re-arm the slave model
   task automatic setup(input logic pol, input logic pha, input logic man);
      cur_cpol = pol; cur_cpha = pha;
      cr_cur = 32'h106 | (32'(pol) << 3) | (32'(pha) << 4) | (32'(man) << 7);
      wr(A_CTRL, cr_cur);
      repeat (2) @(negedge clk);
      slv_pos = pha ? 7 : 0; slv_bits = 0; edges = 0; have_t = 0;
   endtask

   task automatic run(input string tag, input bit clr_isr);
      logic [31:0] d;
      bit seen = 0;
      wr(A_CTRL, cr_cur & ~32'h100);
      for (int i = 0; i < 3000 && !seen; i++) begin
         rd(A_ISR, d);
         seen = d[2];
      end
      chk({tag, " txempty flag"}, 32'(seen), 32'd1);
      wr(A_CTRL, cr_cur);
      if (clr_isr) wr(A_ISR, 32'h3F);
   endtask

   task automatic drain(output int cnt, output logic [7:0] first);
      logic [31:0] d;
      cnt = 0; first = 8'h00;
      for (int i = 0; i < 40; i++) begin
         rd(A_STAT, d);
         if (d[0]) break;
         rd(A_RXD, d);
         if (cnt == 0) first = d[7:0];
         cnt++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int cnt;
      logic [7:0] first;
      time tb;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, d); chk("R1 ctrl", d, 32'h100);
      rd(A_STAT, d); chk("R1 status", d, 32'h05);
      rd(A_SSEL, d); chk("R1 select", d, 32'h0000FFFF);
      rd(A_ISR, d);  chk("R1 isr", d, 32'h0);
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 sck", 32'(spi_sck), 32'd0);
      chk("R1 ss_n", 32'(spi_ss_n), 32'h0000FFFF);

      // R3 R4 R5 vector table
      wr(A_SSEL, 32'h0000FFFE);
      foreach (VEC[k]) begin
         setup(VEC[k][17], VEC[k][16], 1'b1);
         slv_tx = VEC[k][7:0];
         wr(A_TXD, 32'(VEC[k][15:8]));
         run("R3 vector", 1'b1);
         rd(A_RXD, d);
         chk($sformatf("R3 R4 rx byte vec%0d", k), d, 32'(VEC[k][7:0]));
         chk($sformatf("R3 R4 slave got vec%0d", k), 32'(slv_rx), 32'(VEC[k][15:8]));
         chk($sformatf("R4 idle level vec%0d", k), 32'(spi_sck), 32'(VEC[k][17]));
      end
      chk("R5 half period", 32'(hp_min), 32'(DIV * TCLK));

      // R2 inhibit and enable gating
      setup(1'b0, 1'b0, 1'b1);
      slv_tx = 8'h5C;
      wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
      repeat (60) @(negedge clk);
      chk("R2 no sck while inhibited", 32'(edges), 32'd0);
      rd(A_STAT, d); chk("R2 tx still queued", 32'(d[2]), 32'd0);
      wr(A_CTRL, 32'h084);
      repeat (60) @(negedge clk);
      chk("R2 no sck while disabled", 32'(edges), 32'd0);
      run("R2", 1'b1);
      chk("R2 bytes sent after enable", 32'(slv_bits / 8), 32'd2);
      drain(cnt, first);
      chk("R2 rx count", 32'(cnt), 32'd2);

      // R6 back-to-back burst
      setup(1'b1, 1'b1, 1'b1);
      wr(A_TXD, 32'h01); wr(A_TXD, 32'h02); wr(A_TXD, 32'h03);
      run("R6", 1'b0);
      chk("R6 edge count", 32'(edges), 32'd48);
      chk("R6 burst span", 32'((last_t - t_first) / TCLK), 32'(47 * DIV + 2));
      chk("R6 slave last byte", 32'(slv_rx), 32'h03);
      drain(cnt, first);

      // R10 R9 interrupt gating and clear (TX-empty status still pending)
      chk("R10 irq masked", 32'(irq), 32'd0);
      wr(A_IER, 32'h04);
      chk("R10 irq without global", 32'(irq), 32'd0);
      wr(A_GIE, 32'h80000000);
      chk("R10 irq raised", 32'(irq), 32'd1);
      wr(A_ISR, 32'h04);
      rd(A_ISR, d); chk("R9 w1c clears", d, 32'h0);
      chk("R10 irq drops", 32'(irq), 32'd0);

      // R7 R8 FIFO limits
      setup(1'b0, 1'b0, 1'b1);
      slv_tx = 8'hB2;
      for (int i = 0; i < 17; i++) wr(A_TXD, 32'(i));
      rd(A_STAT, d); chk("R7 tx full flag", 32'(d[3]), 32'd1);
      run("R7", 1'b0);
      chk("R7 17th byte dropped", 32'(slv_bits / 8), 32'd16);
      rd(A_STAT, d); chk("R8 rx full status", 32'(d[1]), 32'd1);
      rd(A_ISR, d);  chk("R8 rx full isr", 32'(d[4]), 32'd1);
      wr(A_ISR, 32'h3F);
      slv_tx = 8'h4D;
      wr(A_TXD, 32'h99);
      run("R8", 1'b0);
      rd(A_ISR, d); chk("R8 overrun isr", 32'(d[5]), 32'd1);
      wr(A_ISR, 32'h3F);
      drain(cnt, first);
      chk("R8 overrun byte dropped", 32'(cnt), 32'd16);
      chk("R8 oldest byte kept", 32'(first), 32'hB2);

      // R13 flush bits
      wr(A_TXD, 32'h44); wr(A_TXD, 32'h55);
      wr(A_CTRL, cr_cur | 32'h20);
      rd(A_STAT, d); chk("R13 tx flushed", 32'(d[2]), 32'd1);
      rd(A_CTRL, d); chk("R13 flush bit reads 0", d, cr_cur);
      wr(A_TXD, 32'h66);
      run("R13", 1'b1);
      wr(A_CTRL, cr_cur | 32'h40);
      rd(A_STAT, d); chk("R13 rx flushed", 32'(d[0]), 32'd1);

      // R11 select modes
      wr(A_SSEL, 32'h0000FFFB);
      repeat (2) @(negedge clk);
      chk("R11 manual follows", 32'(spi_ss_n), 32'h0000FFFB);
      setup(1'b0, 1'b0, 1'b0);
      wr(A_SSEL, 32'h0000FFDF);
      repeat (2) @(negedge clk);
      chk("R11 auto idle", 32'(spi_ss_n), 32'h0000FFFF);
      wr(A_TXD, 32'h77);
      wr(A_CTRL, cr_cur & ~32'h100);
      repeat (6) @(negedge clk);
      chk("R11 auto mid byte", 32'(spi_ss_n), 32'h0000FFDF);
      tb = $time;
      repeat (40) @(negedge clk);
      chk("R11 auto after byte", 32'(spi_ss_n), 32'h0000FFFF);
      wr(A_CTRL, cr_cur);

      // R12 soft reset
      wr(A_TXD, 32'h12); wr(A_IER, 32'h3F);
      wr(A_SRST, 32'h0B);
      rd(A_CTRL, d); chk("R12 wrong key ignored", d, cr_cur);
      rd(A_STAT, d); chk("R12 wrong key keeps fifo", 32'(d[2]), 32'd0);
      wr(A_SRST, 32'h0A);
      rd(A_CTRL, d); chk("R12 ctrl default", d, 32'h100);
      rd(A_STAT, d); chk("R12 status default", d, 32'h05);
      rd(A_SSEL, d); chk("R12 select default", d, 32'h0000FFFF);
      rd(A_IER, d);  chk("R12 enable default", d, 32'h0);

      summary();
      $finish;
   end
endmodule